// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Block

This block is the software-visible face of a multi-channel DMA engine. A processor reaches it through a 32-bit word-addressed register port. Through that port it programs a small global area, one five-word window per channel, and a read-only identification area. The block stores every channel's source, destination, next-descriptor pointer, control word and configuration word. It passes all of them, plus the global configuration, to the transfer engine on plain output pins.

The engine reports completion and failure by pulsing one terminal-count strobe or one error strobe per channel. The block holds each of these as a raw sticky flag. Software clears a flag by writing a one to the matching bit of a clear register.

There are no separate mask registers. Bit 15 of a channel's configuration word enables its terminal-count interrupt, and bit 14 enables its error interrupt. Software can read each status raw or masked. A single level interrupt output is high while any masked flag is set. The channel count is a parameter, 8 or 2.

Requests arrive on a valid-qualified port that accepts one access every cycle and never stalls. A write takes effect at the clock edge where `acc_valid` is high. A read returns its data one cycle later with `rsp_valid` high for exactly one cycle. The read data reflect the register state before any write in that same edge. The response has no ready signal, so the requester must take it in the cycle it appears.

Top module: `dmac_csr`

## Requirements
- R1: After reset every register and flag is zero, `irq` is low, `ctrl_enable` is low and `rsp_valid` is low.
- R2: The channel n window starts at byte offset 0x100 + 32*n and holds five words: source, destination, next pointer, control, configuration. Each word reads back what was last written. Words 5 to 7 of a window, and any window whose index is NCH or higher, read zero and ignore writes. Each read response appears exactly one cycle after the request.
- R3: A one on `tc_set[n]` or `err_set[n]` sets the matching raw flag at the next edge. Offset 0x14 reads the raw terminal-count flags and offset 0x18 reads the raw error flags, in bits NCH-1:0. A flag never becomes set without its strobe.
- R4: Writing to 0x08 clears every terminal-count flag whose bit is one in the written data. Writing to 0x10 does the same for the error flags. Zero bits in the data leave their flags unchanged.
- R5: When a set strobe and a clear bit hit the same flag in the same cycle, the flag ends set.
- R6: Offset 0x04 reads the raw terminal-count flags ANDed with configuration bit 15 of each channel. Offset 0x0C reads the raw error flags ANDed with configuration bit 14. Offset 0x00 reads the OR of those two values.
- R7: `irq` is high exactly when the value readable at offset 0x00 is non-zero.
- R8: Offset 0x1C reads a bitmap with bit n equal to configuration bit 0 of channel n.
- R9: Offset 0x30 is a read/write global configuration word, driven on `glb_cfg`, and `ctrl_enable` is its bit 0. Offset 0x34 is a read/write sync word. `ctrl_enable` changes only after a write.
- R10: Byte offsets 0xFE0 to 0xFFC read one identification byte per word, in this order: 0x80 (0x81 when NCH is 2), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Offsets 0x20 to 0x2C (software requests), 0x08 and 0x10 on read, and every other unmapped offset read zero. Writes to them change no register.
- R12: `ch_src`, `ch_dst`, `ch_next`, `ch_ctrl` and `ch_cfg` carry channel n's registers in bits 32n+31:32n. Each changes only after a write to that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 12 | Byte offset; bits 1:0 are ignored |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| tc_set | input | NCH | Terminal-count flag set strobes from the engine |
| err_set | input | NCH | Error flag set strobes from the engine |
| irq | output | 1 | Level interrupt |
| ctrl_enable | output | 1 | Controller enable, global configuration bit 0 |
| glb_cfg | output | 32 | Global configuration word |
| ch_src | output | NCH*32 | Source words of all channels |
| ch_dst | output | NCH*32 | Destination words of all channels |
| ch_next | output | NCH*32 | Next-pointer words of all channels |
| ch_ctrl | output | NCH*32 | Control words of all channels |
| ch_cfg | output | NCH*32 | Configuration words of all channels |

## Verification
The bench builds the two-channel variant. This lets it reach windows beyond the channel count and the 0x81 identification byte. A decoder that ignored the channel count would store writes to window 5, and a read of that window would then return non-zero.

A set strobe and a clear of the same bit are driven together. A clear-first priority would leave the flag low and drop a completion.

The masks are switched through configuration bits 15 and 14 while flags are already pending. An interrupt tied to the raw flags, or a mask taken from the wrong bit, shows up at once on `irq` and in the masked reads.

Writes to the software-request and unmapped offsets are each followed by reads of all global state. An address decode that aliased them onto a live register would change a later read.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SLOT_W = 3;   // channel index field width in the address

  // global register word indices (byte offset / 4)
  localparam logic [3:0] GW_STAT    = 4'd0;
  localparam logic [3:0] GW_TC_MSK  = 4'd1;
  localparam logic [3:0] GW_TC_CLR  = 4'd2;
  localparam logic [3:0] GW_ERR_MSK = 4'd3;
  localparam logic [3:0] GW_ERR_CLR = 4'd4;
  localparam logic [3:0] GW_TC_RAW  = 4'd5;
  localparam logic [3:0] GW_ERR_RAW = 4'd6;
  localparam logic [3:0] GW_ENBL    = 4'd7;
  localparam logic [3:0] GW_CFG     = 4'd12;
  localparam logic [3:0] GW_SYNC    = 4'd13;

  // channel window word indices
  typedef enum logic [2:0] {
    CW_SRC = 3'd0, CW_DST = 3'd1, CW_NEXT = 3'd2, CW_CTRL = 3'd3, CW_CFG = 3'd4
  } chan_word_e;

  // configuration bit positions decoded by this block
  localparam int CB_ENABLE   = 0;
  localparam int CB_ERR_MASK = 14;
  localparam int CB_TC_MASK  = 15;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
    case (idx)
      3'd0:    id_byte = (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h0A;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dmac_flag_bank.sv
module dmac_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] raw_o
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_en_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_o <= '0;
    else        raw_o <= (raw_o & ~clr_eff) | set_i;
  end

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));

  p_clear_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && (set_i == '0)) |=> ((raw_o & $past(clr_mask_i)) == '0));

  p_no_spontaneous_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((raw_o & ~$past(raw_o)) == '0));
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_csr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [2:0]    word_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic [DW-1:0] next_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] cfg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o  <= '0;
      dst_o  <= '0;
      next_o <= '0;
      ctrl_o <= '0;
      cfg_o  <= '0;
    end else if (wr_en_i) begin
      case (word_i)
        CW_SRC:  src_o  <= wdata_i;
        CW_DST:  dst_o  <= wdata_i;
        CW_NEXT: next_o <= wdata_i;
        CW_CTRL: ctrl_o <= wdata_i;
        CW_CFG:  cfg_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(cfg_o));
endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
  import dmac_csr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [DATA_W-1:0]     acc_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  input  logic [NCH-1:0]        tc_set,
  input  logic [NCH-1:0]        err_set,
  output logic                  irq,
  output logic                  ctrl_enable,
  output logic [DATA_W-1:0]     glb_cfg,
  output logic [NCH*DATA_W-1:0] ch_src,
  output logic [NCH*DATA_W-1:0] ch_dst,
  output logic [NCH*DATA_W-1:0] ch_next,
  output logic [NCH*DATA_W-1:0] ch_ctrl,
  output logic [NCH*DATA_W-1:0] ch_cfg
);
  localparam int DW = DATA_W;

  // address decode
  logic              wr, rd;
  logic              is_glb, is_chan, is_id, chan_ok;
  logic [3:0]        gword;
  logic [SLOT_W-1:0] cidx;
  logic [2:0]        cword;

  assign wr      = acc_valid && acc_write;
  assign rd      = acc_valid && !acc_write;
  assign is_glb  = (acc_addr[11:6] == 6'd0);
  assign is_chan = (acc_addr[11:8] == 4'h1);
  assign is_id   = (acc_addr[11:5] == 7'h7F);
  assign gword   = acc_addr[5:2];
  assign cidx    = acc_addr[7:5];
  assign cword   = acc_addr[4:2];
  assign chan_ok = is_chan && (32'(cidx) < 32'(NCH));

  // per-channel register windows
  logic [DW-1:0] src_a [NCH];
  logic [DW-1:0] dst_a [NCH];
  logic [DW-1:0] nxt_a [NCH];
  logic [DW-1:0] ctl_a [NCH];
  logic [DW-1:0] cfg_a [NCH];
  logic [NCH-1:0] tc_mask, err_mask, en_map;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmac_chan_regs #(.DW(DW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(wr && chan_ok && (cidx == SLOT_W'(g))),
      .word_i (cword),
      .wdata_i(acc_wdata),
      .src_o  (src_a[g]),
      .dst_o  (dst_a[g]),
      .next_o (nxt_a[g]),
      .ctrl_o (ctl_a[g]),
      .cfg_o  (cfg_a[g])
    );
    assign ch_src [g*DW +: DW] = src_a[g];
    assign ch_dst [g*DW +: DW] = dst_a[g];
    assign ch_next[g*DW +: DW] = nxt_a[g];
    assign ch_ctrl[g*DW +: DW] = ctl_a[g];
    assign ch_cfg [g*DW +: DW] = cfg_a[g];
    assign tc_mask[g]  = cfg_a[g][CB_TC_MASK];
    assign err_mask[g] = cfg_a[g][CB_ERR_MASK];
    assign en_map[g]   = cfg_a[g][CB_ENABLE];
  end

  // sticky flags
  logic [NCH-1:0] tc_raw, err_raw, tc_act, err_act;

  dmac_flag_bank #(.N(NCH)) u_tc (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (tc_set),
    .clr_en_i  (wr && is_glb && (gword == GW_TC_CLR)),
    .clr_mask_i(acc_wdata[NCH-1:0]),
    .raw_o     (tc_raw)
  );

  dmac_flag_bank #(.N(NCH)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (err_set),
    .clr_en_i  (wr && is_glb && (gword == GW_ERR_CLR)),
    .clr_mask_i(acc_wdata[NCH-1:0]),
    .raw_o     (err_raw)
  );

  assign tc_act  = tc_raw & tc_mask;
  assign err_act = err_raw & err_mask;
  assign irq     = |(tc_act | err_act);

  // global words
  logic [DW-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_cfg <= '0;
      sync_q  <= '0;
    end else if (wr && is_glb) begin
      if (gword == GW_CFG)  glb_cfg <= acc_wdata;
      if (gword == GW_SYNC) sync_q  <= acc_wdata;
    end
  end

  assign ctrl_enable = glb_cfg[0];

  // read path
  logic [DW-1:0] rd_mux, chan_word;

  always_comb begin
    chan_word = '0;
    for (int k = 0; k < NCH; k++) begin
      if (cidx == SLOT_W'(k)) begin
        case (cword)
          CW_SRC:  chan_word = src_a[k];
          CW_DST:  chan_word = dst_a[k];
          CW_NEXT: chan_word = nxt_a[k];
          CW_CTRL: chan_word = ctl_a[k];
          CW_CFG:  chan_word = cfg_a[k];
          default: chan_word = '0;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (is_id) begin
      rd_mux = DW'(id_byte(cword, NCH));
    end else if (chan_ok) begin
      rd_mux = chan_word;
    end else if (is_glb) begin
      case (gword)
        GW_STAT:    rd_mux = DW'(tc_act | err_act);
        GW_TC_MSK:  rd_mux = DW'(tc_act);
        GW_ERR_MSK: rd_mux = DW'(err_act);
        GW_TC_RAW:  rd_mux = DW'(tc_raw);
        GW_ERR_RAW: rd_mux = DW'(err_raw);
        GW_ENBL:    rd_mux = DW'(en_map);
        GW_CFG:     rd_mux = glb_cfg;
        GW_SYNC:    rd_mux = sync_q;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  p_rsp_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);

  p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctrl_enable));
endmodule

// File: tb/test_dmac_csr.sv
module test_dmac_csr;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0, acc_write = 1'b0;
  logic [11:0]       acc_addr = '0;
  logic [31:0]       acc_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [NCH-1:0]    tc_set = '0, err_set = '0;
  logic              irq, ctrl_enable;
  logic [31:0]       glb_cfg;
  logic [NCH*32-1:0] ch_src, ch_dst, ch_next, ch_ctrl, ch_cfg;

  dmac_csr #(.NCH(NCH)) i_dmac_csr (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .tc_set(tc_set), .err_set(err_set), .irq(irq),
    .ctrl_enable(ctrl_enable), .glb_cfg(glb_cfg), .ch_src(ch_src),
    .ch_dst(ch_dst), .ch_next(ch_next), .ch_ctrl(ch_ctrl), .ch_cfg(ch_cfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_ch [NCH][5];
  logic [31:0] m_gcfg = '0, m_sync = '0;
  logic [NCH-1:0] m_tc = '0, m_err = '0;
  logic [7:0] ids [8];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] tcm();
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = m_ch[i][4][15];
    return r;
  endfunction

  function automatic logic [NCH-1:0] erm();
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = m_ch[i][4][14];
    return r;
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    int w;
    int c;
    logic [NCH-1:0] en;
    if (a >= 12'hFE0) return 32'(ids[a[4:2]]);
    if (a >= 12'h100 && a < 12'h200) begin
      c = int'(a[7:5]);
      w = int'(a[4:2]);
      if (c < NCH && w < 5) return m_ch[c][w];
      return 0;
    end
    if (a >= 12'h40) return 0;
    for (int i = 0; i < NCH; i++) en[i] = m_ch[i][4][0];
    case (a[5:2])
      4'd0:  return 32'((m_tc & tcm()) | (m_err & erm()));
      4'd1:  return 32'(m_tc & tcm());
      4'd3:  return 32'(m_err & erm());
      4'd5:  return 32'(m_tc);
      4'd6:  return 32'(m_err);
      4'd7:  return 32'(en);
      4'd12: return m_gcfg;
      4'd13: return m_sync;
      default: return 0;
    endcase
  endfunction

  task automatic mwrite(input logic [11:0] a, input logic [31:0] d);
    int c;
    int w;
    if (a >= 12'h100 && a < 12'h200) begin
      c = int'(a[7:5]);
      w = int'(a[4:2]);
      if (c < NCH && w < 5) m_ch[c][w] = d;
    end else if (a < 12'h40) begin
      if (a[5:2] == 4'd2)  m_tc  = m_tc & ~d[NCH-1:0];
      if (a[5:2] == 4'd4)  m_err = m_err & ~d[NCH-1:0];
      if (a[5:2] == 4'd12) m_gcfg = d;
      if (a[5:2] == 4'd13) m_sync = d;
    end
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic cyc(input bit v, input bit w, input logic [11:0] a, input logic [31:0] d,
                     input logic [NCH-1:0] ts, input logic [NCH-1:0] es, input string tag);
    logic [31:0] exp_rd;
    logic [NCH*32-1:0] exp_cfg;
    bit exp_irq;
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
    tc_set = ts; err_set = es;
    exp_rd = (v && !w) ? mread(a) : 32'd0;
    if (v && w) mwrite(a, d);
    m_tc = m_tc | ts;       // set wins over same-cycle clear
    m_err = m_err | es;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0; tc_set = '0; err_set = '0;
    check(rsp_valid == (v && !w), tag, 64'(rsp_valid), 64'(v && !w));
    if (v && !w) check(rsp_rdata == exp_rd, tag, 64'(rsp_rdata), 64'(exp_rd));
    exp_irq = |((m_tc & tcm()) | (m_err & erm()));
    check(irq == exp_irq, "R7", 64'(irq), 64'(exp_irq));
    check(ctrl_enable == m_gcfg[0] && glb_cfg == m_gcfg, "R9", 64'(glb_cfg), 64'(m_gcfg));
    for (int i = 0; i < NCH; i++) exp_cfg[i*32 +: 32] = m_ch[i][4];
    check(ch_cfg == exp_cfg, "R12", 64'(ch_cfg), 64'(exp_cfg));
    check(ch_src[31:0] == m_ch[0][0] && ch_ctrl[63:32] == m_ch[1][3], "R12",
          64'(ch_src[31:0]), 64'(m_ch[0][0]));
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'd0, '0, '0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, '0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ids[0] = (NCH == 8) ? 8'h80 : 8'h81; ids[1] = 8'h10; ids[2] = 8'h04; ids[3] = 8'h0A;
    ids[4] = 8'h0D; ids[5] = 8'hF0; ids[6] = 8'h05; ids[7] = 8'hB1;
    for (int i = 0; i < NCH; i++) for (int j = 0; j < 5; j++) m_ch[i][j] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(irq == 1'b0 && rsp_valid == 1'b0 && ctrl_enable == 1'b0, "R1", 64'(irq), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 'h40; a += 4) rd(12'(a), "R1");
    rd(12'h110, "R1");
    // R2: channel windows, R12 outputs
    for (int c = 0; c < NCH; c++)
      for (int j = 0; j < 5; j++) wr(12'(12'h100 + c*32 + j*4), 32'hA500_0000 + 32'(c*16 + j), "R2");
    for (int c = 0; c < NCH; c++)
      for (int j = 0; j < 8; j++) rd(12'(12'h100 + c*32 + j*4), "R2");
    // R2: out-of-range window and spare words
    wr(12'h1A0, 32'hDEAD_BEEF, "R2");
    wr(12'h114, 32'h1234_5678, "R2");
    rd(12'h1A0, "R2"); rd(12'h114, "R2"); rd(12'h100, "R2");
    // R10: identification bytes
    for (int j = 0; j < 8; j++) rd(12'(12'hFE0 + j*4), "R10");
    // R9: global config and sync
    wr(12'h030, 32'h0000_0007, "R9"); rd(12'h030, "R9");
    wr(12'h034, 32'hCAFE_0001, "R9"); rd(12'h034, "R9");
    wr(12'h030, 32'h0000_0006, "R9"); rd(12'h030, "R9");
    // R8: enable bitmap
    wr(12'h110, 32'h0000_0001, "R8"); rd(12'h01C, "R8");
    wr(12'h130, 32'h0000_0001, "R8"); rd(12'h01C, "R8");
    wr(12'h110, 32'h0000_0000, "R8"); rd(12'h01C, "R8");
    // R3: raw flags, no mask -> irq low
    cyc(1'b0, 1'b0, 12'h0, 32'd0, 2'b10, 2'b00, "R3");
    rd(12'h014, "R3"); rd(12'h000, "R6"); rd(12'h004, "R6");
    cyc(1'b0, 1'b0, 12'h0, 32'd0, 2'b00, 2'b01, "R3");
    rd(12'h018, "R3"); rd(12'h00C, "R6");
    // R6/R7: enable masks through channel config bits 15 and 14
    wr(12'h130, 32'h0000_8001, "R6"); rd(12'h004, "R6"); rd(12'h000, "R6");
    wr(12'h110, 32'h0000_4000, "R6"); rd(12'h00C, "R6"); rd(12'h000, "R6");
    wr(12'h130, 32'h0000_0001, "R7"); rd(12'h000, "R7");
    // R4: clear by writing ones
    wr(12'h010, 32'h0000_0002, "R4"); rd(12'h018, "R4");
    wr(12'h010, 32'h0000_0001, "R4"); rd(12'h018, "R4"); rd(12'h000, "R4");
    wr(12'h008, 32'h0000_0000, "R4"); rd(12'h014, "R4");
    // R5: set and clear of the same bit in one cycle
    cyc(1'b1, 1'b1, 12'h008, 32'h0000_0003, 2'b10, 2'b00, "R5");
    rd(12'h014, "R5");
    cyc(1'b1, 1'b1, 12'h008, 32'h0000_0002, 2'b01, 2'b00, "R5");
    rd(12'h014, "R5");
    wr(12'h130, 32'h0000_8000, "R7");
    cyc(1'b0, 1'b0, 12'h0, 32'd0, 2'b10, 2'b00, "R7");
    rd(12'h004, "R7");
    wr(12'h008, 32'h0000_0003, "R7"); rd(12'h000, "R7");
    // R11: software request and unmapped offsets
    wr(12'h020, 32'hFFFF_FFFF, "R11"); wr(12'h024, 32'hFFFF_FFFF, "R11");
    wr(12'h028, 32'hFFFF_FFFF, "R11"); wr(12'h02C, 32'hFFFF_FFFF, "R11");
    wr(12'h040, 32'hFFFF_FFFF, "R11"); wr(12'h200, 32'hFFFF_FFFF, "R11");
    wr(12'h800, 32'hFFFF_FFFF, "R11");
    for (int a = 0; a < 'h40; a += 4) rd(12'(a), "R11");
    rd(12'h040, "R11"); rd(12'h200, "R11"); rd(12'hFDC, "R11");
    repeat (2) cyc(1'b0, 1'b0, 12'h0, 32'd0, '0, '0, "R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule